// File: doc/BRIEF.md
# Two-Unit Banked Register File with Swapping Data Banks

This block stores the operands of one cluster that pairs a load/store unit (LS) with an arithmetic unit (AU). Each unit owns a private space. The LS owns eight 32-bit address registers and the AU owns eight 40-bit accumulators. Sixteen 32-bit data registers sit between the two units in two groups of eight, named bank P and bank Q. A one-bit bank-swap input arrives with every packet and decides which group each unit reaches that cycle. The two units can never reach the same group in the same cycle, so a value loaded by the LS becomes an AU operand once the swap bit flips.

Every group of eight is split into an even half and an odd half. Each half is a four-entry store with two read ports and one write port. A paired write names an even index m and lands on m and m+1, so its two halves always go to different stores. This lets a double load update two address registers and two data registers in one cycle. A double store can read two address and two data registers at once. The AU can read two data operands while it updates an accumulator pair. Reads are combinational. Writes land at the rising clock edge.

Top module: `pp_regfile`

## Requirements
- R1: After an active-low asynchronous reset, every address register, accumulator and data register reads as zero.
- R2: The LS has two address read ports and two address write ports that may target any index in the same cycle. When both write ports name the same index, write port 1 supplies the stored value.
- R3: The AU accumulators are 40 bits wide. A paired accumulator write to even index m stores `au_c_wdata0` in m and `au_c_wdata1` in m+1.
- R4: With `pp_idx` = 0 the LS reaches bank P and the AU reaches bank Q. With `pp_idx` = 1 the LS reaches bank Q and the AU reaches bank P. Data written through one unit can be read back through the other after the swap.
- R5: A write takes effect at the rising edge. A read of the written register in the same cycle returns the previous contents. A register that no write port targets keeps its value.
- R6: A paired data write (`*_wpair` = 1) at even index m stores `wdata0` in m and `wdata1` in m+1. A single write (`*_wpair` = 0) stores `wdata0` at any index and changes no other register.
- R7: A paired write at an odd index is illegal. In that same cycle `ls_err` (LS data write) or `au_err` (AU data or accumulator write) is 1, and that faulty write changes no register. Other writes in the cycle still take effect.
- R8: In one cycle the design accepts two address writes, one LS data write, one AU data write and one accumulator write, each of them paired or single. All of them land without disturbing one another.
- R9: Each space has two read ports per unit. The two ports return the registers at their own indices independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pp_idx | input | 1 | Bank-swap bit of the current packet |
| ls_a_ridx0 | input | 3 | LS address read index, port 0 |
| ls_a_ridx1 | input | 3 | LS address read index, port 1 |
| ls_a_rdata0 | output | 32 | LS address read data, port 0 |
| ls_a_rdata1 | output | 32 | LS address read data, port 1 |
| ls_a_we0 | input | 1 | LS address write enable, port 0 |
| ls_a_widx0 | input | 3 | LS address write index, port 0 |
| ls_a_wdata0 | input | 32 | LS address write data, port 0 |
| ls_a_we1 | input | 1 | LS address write enable, port 1 |
| ls_a_widx1 | input | 3 | LS address write index, port 1 |
| ls_a_wdata1 | input | 32 | LS address write data, port 1 |
| ls_d_ridx0 | input | 3 | LS data read index, port 0 |
| ls_d_ridx1 | input | 3 | LS data read index, port 1 |
| ls_d_rdata0 | output | 32 | LS data read data, port 0 |
| ls_d_rdata1 | output | 32 | LS data read data, port 1 |
| ls_d_we | input | 1 | LS data write enable |
| ls_d_wpair | input | 1 | LS data write is paired |
| ls_d_widx | input | 3 | LS data write index |
| ls_d_wdata0 | input | 32 | LS data for index m |
| ls_d_wdata1 | input | 32 | LS data for index m+1 |
| ls_err | output | 1 | Illegal odd paired LS data write |
| au_d_ridx0 | input | 3 | AU data read index, port 0 |
| au_d_ridx1 | input | 3 | AU data read index, port 1 |
| au_d_rdata0 | output | 32 | AU data read data, port 0 |
| au_d_rdata1 | output | 32 | AU data read data, port 1 |
| au_d_we | input | 1 | AU data write enable |
| au_d_wpair | input | 1 | AU data write is paired |
| au_d_widx | input | 3 | AU data write index |
| au_d_wdata0 | input | 32 | AU data for index m |
| au_d_wdata1 | input | 32 | AU data for index m+1 |
| au_c_ridx0 | input | 3 | Accumulator read index, port 0 |
| au_c_ridx1 | input | 3 | Accumulator read index, port 1 |
| au_c_rdata0 | output | 40 | Accumulator read data, port 0 |
| au_c_rdata1 | output | 40 | Accumulator read data, port 1 |
| au_c_we | input | 1 | Accumulator write enable |
| au_c_wpair | input | 1 | Accumulator write is paired |
| au_c_widx | input | 3 | Accumulator write index |
| au_c_wdata0 | input | 40 | Accumulator data for index m |
| au_c_wdata1 | input | 40 | Accumulator data for index m+1 |
| au_err | output | 1 | Illegal odd paired AU data or accumulator write |

## Verification
The main collision is a write and a read of the same register in one cycle. A second collision is an illegal paired write that coincides with legal writes from the other unit or to another space. Every operation cycle drives all five write paths at once. Each read port is aimed at its own write target, and before the edge the bench compares the reads with the old model contents. The error outputs are checked in that same cycle.

After every operation the bench reads back all four spaces under both swap values. This shows which writes landed and which were suppressed. It also shows that a suppressed pair left both m and m+1 untouched while the neighbouring legal writes still landed.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int unsigned RF_DATA_W   = 32;
   localparam int unsigned RF_ACC_W    = 40;
   localparam int unsigned RF_GRP_REGS = 8;

   // which shared group the load/store unit reaches
   typedef enum logic {
      LS_ON_P = 1'b0,
      LS_ON_Q = 1'b1
   } bank_map_e;
endpackage

// File: rtl/rf_bank.sv
// One half-group store: two combinational reads, NW write ports.
module rf_bank #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned NW    = 1,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NW-1:0]          we,
   input  logic [NW-1:0][AW-1:0]  waddr,
   input  logic [NW-1:0][W-1:0]   wdata,
   input  logic [AW-1:0]          raddr0,
   input  logic [AW-1:0]          raddr1,
   output logic [W-1:0]           rdata0,
   output logic [W-1:0]           rdata1
);
   logic [DEPTH-1:0][W-1:0] mem;

   if (NW < 1 || NW > 2) begin : g_bad_nw
      $error("rf_bank: NW must be 1 or 2");
   end

   // later port wins on an address collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else begin
         for (int p = 0; p < int'(NW); p++) begin
            if (we[p]) mem[waddr[p]] <= wdata[p];
         end
      end
   end

   assign rdata0 = mem[raddr0];
   assign rdata1 = mem[raddr1];

   // R2 and R6: the highest-numbered active port decides the stored word
   a_r2_last_port_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we[NW-1] |=> mem[$past(waddr[NW-1])] == $past(wdata[NW-1]));

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(|we) |=> $stable(mem));
endmodule

// File: rtl/rf_group.sv
// Eight-style register group made of an even and an odd half-store.
module rf_group #(
   parameter int unsigned W         = 32,
   parameter int unsigned REGS      = 8,
   parameter bit          PAIR_ONLY = 1'b1,
   localparam int unsigned IW       = $clog2(REGS),
   localparam int unsigned HD       = REGS / 2,
   localparam int unsigned HW       = IW - 1,
   localparam int unsigned NWB      = PAIR_ONLY ? 1 : 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            we,
   input  logic [1:0][IW-1:0]    widx,
   input  logic [1:0][W-1:0]     wdata,
   input  logic [IW-1:0]         ridx0,
   input  logic [IW-1:0]         ridx1,
   output logic [W-1:0]          rdata0,
   output logic [W-1:0]          rdata1
);
   if (REGS < 4 || (REGS & (REGS - 1)) != 0) begin : g_bad_regs
      $error("rf_group: REGS must be a power of two, at least 4");
   end

   logic [1:0][W-1:0] half_r0;
   logic [1:0][W-1:0] half_r1;

   for (genvar b = 0; b < 2; b++) begin : g_half
      logic [NWB-1:0]         bwe;
      logic [NWB-1:0][HW-1:0] bwa;
      logic [NWB-1:0][W-1:0]  bwd;

      if (PAIR_ONLY) begin : g_one_wr
         // single write port per half: ports 0 and 1 must split by parity
         logic hit0, hit1;
         assign hit0   = we[0] && (widx[0][0] == 1'(b));
         assign hit1   = we[1] && (widx[1][0] == 1'(b));
         assign bwe[0] = hit0 | hit1;
         assign bwa[0] = hit1 ? widx[1][IW-1:1] : widx[0][IW-1:1];
         assign bwd[0] = hit1 ? wdata[1] : wdata[0];

         a_r6_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit0 && hit1));
      end else begin : g_two_wr
         for (genvar p = 0; p < 2; p++) begin : g_port
            assign bwe[p] = we[p] && (widx[p][0] == 1'(b));
            assign bwa[p] = widx[p][IW-1:1];
            assign bwd[p] = wdata[p];
         end
      end

      rf_bank #(.W(W), .DEPTH(HD), .NW(NWB)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (bwe),
         .waddr  (bwa),
         .wdata  (bwd),
         .raddr0 (ridx0[IW-1:1]),
         .raddr1 (ridx1[IW-1:1]),
         .rdata0 (half_r0[b]),
         .rdata1 (half_r1[b])
      );
   end

   assign rdata0 = half_r0[ridx0[0]];
   assign rdata1 = half_r1[ridx1[0]];
endmodule

// File: rtl/rf_pair_wr.sv
// Expands one paired-or-single write request into two group write ports.
module rf_pair_wr #(
   parameter int unsigned W  = 32,
   parameter int unsigned IW = 3
) (
   input  logic               en,
   input  logic               pair,
   input  logic [IW-1:0]      idx,
   input  logic [W-1:0]       d0,
   input  logic [W-1:0]       d1,
   output logic [1:0]         we,
   output logic [1:0][IW-1:0] widx,
   output logic [1:0][W-1:0]  wdata,
   output logic               err
);
   assign err      = en & pair & idx[0];
   assign we[0]    = en & ~err;
   assign we[1]    = en & pair & ~err;
   assign widx[0]  = idx;
   assign widx[1]  = {idx[IW-1:1], 1'b1};
   assign wdata[0] = d0;
   assign wdata[1] = d1;
endmodule

// File: rtl/pp_regfile.sv
module pp_regfile #(
   parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
   parameter int unsigned ACC_W    = rf_pkg::RF_ACC_W,
   parameter int unsigned GRP_REGS = rf_pkg::RF_GRP_REGS,
   localparam int unsigned IW      = $clog2(GRP_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pp_idx,
   input  logic [IW-1:0]     ls_a_ridx0,
   input  logic [IW-1:0]     ls_a_ridx1,
   output logic [DATA_W-1:0] ls_a_rdata0,
   output logic [DATA_W-1:0] ls_a_rdata1,
   input  logic              ls_a_we0,
   input  logic [IW-1:0]     ls_a_widx0,
   input  logic [DATA_W-1:0] ls_a_wdata0,
   input  logic              ls_a_we1,
   input  logic [IW-1:0]     ls_a_widx1,
   input  logic [DATA_W-1:0] ls_a_wdata1,
   input  logic [IW-1:0]     ls_d_ridx0,
   input  logic [IW-1:0]     ls_d_ridx1,
   output logic [DATA_W-1:0] ls_d_rdata0,
   output logic [DATA_W-1:0] ls_d_rdata1,
   input  logic              ls_d_we,
   input  logic              ls_d_wpair,
   input  logic [IW-1:0]     ls_d_widx,
   input  logic [DATA_W-1:0] ls_d_wdata0,
   input  logic [DATA_W-1:0] ls_d_wdata1,
   output logic              ls_err,
   input  logic [IW-1:0]     au_d_ridx0,
   input  logic [IW-1:0]     au_d_ridx1,
   output logic [DATA_W-1:0] au_d_rdata0,
   output logic [DATA_W-1:0] au_d_rdata1,
   input  logic              au_d_we,
   input  logic              au_d_wpair,
   input  logic [IW-1:0]     au_d_widx,
   input  logic [DATA_W-1:0] au_d_wdata0,
   input  logic [DATA_W-1:0] au_d_wdata1,
   input  logic [IW-1:0]     au_c_ridx0,
   input  logic [IW-1:0]     au_c_ridx1,
   output logic [ACC_W-1:0]  au_c_rdata0,
   output logic [ACC_W-1:0]  au_c_rdata1,
   input  logic              au_c_we,
   input  logic              au_c_wpair,
   input  logic [IW-1:0]     au_c_widx,
   input  logic [ACC_W-1:0]  au_c_wdata0,
   input  logic [ACC_W-1:0]  au_c_wdata1,
   output logic              au_err
);
   import rf_pkg::*;

   if (ACC_W < DATA_W) begin : g_bad_acc
      $error("pp_regfile: accumulators may not be narrower than data");
   end

   // ---------------- address space (LS only, two free write ports)
   rf_group #(.W(DATA_W), .REGS(GRP_REGS), .PAIR_ONLY(1'b0)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     ({ls_a_we1, ls_a_we0}),
      .widx   ({ls_a_widx1, ls_a_widx0}),
      .wdata  ({ls_a_wdata1, ls_a_wdata0}),
      .ridx0  (ls_a_ridx0),
      .ridx1  (ls_a_ridx1),
      .rdata0 (ls_a_rdata0),
      .rdata1 (ls_a_rdata1)
   );

   // ---------------- accumulator space (AU only)
   logic [1:0]             c_we;
   logic [1:0][IW-1:0]     c_widx;
   logic [1:0][ACC_W-1:0]  c_wdata;
   logic                   c_err;

   rf_pair_wr #(.W(ACC_W), .IW(IW)) u_acc_pw (
      .en (au_c_we), .pair (au_c_wpair), .idx (au_c_widx),
      .d0 (au_c_wdata0), .d1 (au_c_wdata1),
      .we (c_we), .widx (c_widx), .wdata (c_wdata), .err (c_err)
   );

   rf_group #(.W(ACC_W), .REGS(GRP_REGS), .PAIR_ONLY(1'b1)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (c_we),
      .widx   (c_widx),
      .wdata  (c_wdata),
      .ridx0  (au_c_ridx0),
      .ridx1  (au_c_ridx1),
      .rdata0 (au_c_rdata0),
      .rdata1 (au_c_rdata1)
   );

   // ---------------- shared data groups with swapping access
   logic [1:0]              lsd_we, aud_we;
   logic [1:0][IW-1:0]      lsd_widx, aud_widx;
   logic [1:0][DATA_W-1:0]  lsd_wdata, aud_wdata;
   logic                    lsd_err, aud_err;

   rf_pair_wr #(.W(DATA_W), .IW(IW)) u_ls_pw (
      .en (ls_d_we), .pair (ls_d_wpair), .idx (ls_d_widx),
      .d0 (ls_d_wdata0), .d1 (ls_d_wdata1),
      .we (lsd_we), .widx (lsd_widx), .wdata (lsd_wdata), .err (lsd_err)
   );

   rf_pair_wr #(.W(DATA_W), .IW(IW)) u_au_pw (
      .en (au_d_we), .pair (au_d_wpair), .idx (au_d_widx),
      .d0 (au_d_wdata0), .d1 (au_d_wdata1),
      .we (aud_we), .widx (aud_widx), .wdata (aud_wdata), .err (aud_err)
   );

   bank_map_e              map;
   logic [1:0][DATA_W-1:0] grp_r0, grp_r1;

   assign map = bank_map_e'(pp_idx);

   // group 0 is bank P, group 1 is bank Q; group g serves the LS when map == g
   for (genvar g = 0; g < 2; g++) begin : g_shared
      logic ls_owns;
      assign ls_owns = (map == bank_map_e'(g));

      rf_group #(.W(DATA_W), .REGS(GRP_REGS), .PAIR_ONLY(1'b1)) u_grp (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (ls_owns ? lsd_we    : aud_we),
         .widx   (ls_owns ? lsd_widx  : aud_widx),
         .wdata  (ls_owns ? lsd_wdata : aud_wdata),
         .ridx0  (ls_owns ? ls_d_ridx0 : au_d_ridx0),
         .ridx1  (ls_owns ? ls_d_ridx1 : au_d_ridx1),
         .rdata0 (grp_r0[g]),
         .rdata1 (grp_r1[g])
      );
   end

   assign ls_d_rdata0 = grp_r0[pp_idx];
   assign ls_d_rdata1 = grp_r1[pp_idx];
   assign au_d_rdata0 = grp_r0[~pp_idx];
   assign au_d_rdata1 = grp_r1[~pp_idx];

   assign ls_err = lsd_err;
   assign au_err = aud_err | c_err;

   // R5: a legal single LS write is seen in the next cycle under the same mapping
   a_r5_ls_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_d_we && !ls_d_wpair) |=>
         (!$stable(pp_idx) || (ls_d_ridx0 != $past(ls_d_widx)) ||
          (ls_d_rdata0 == $past(ls_d_wdata0))));

   // R7: an illegal LS pair leaves the LS-visible group untouched
   a_r7_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      ls_err |=> (!$stable(pp_idx) || !$stable(ls_d_ridx0) || $stable(ls_d_rdata0)));
endmodule

// File: tb/pp_regfile_bench.sv
`timescale 1ns/1ps
module pp_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pp_idx;
   logic [2:0]  ls_a_ridx0, ls_a_ridx1, ls_a_widx0, ls_a_widx1;
   logic [31:0] ls_a_rdata0, ls_a_rdata1, ls_a_wdata0, ls_a_wdata1;
   logic        ls_a_we0, ls_a_we1;
   logic [2:0]  ls_d_ridx0, ls_d_ridx1, ls_d_widx;
   logic [31:0] ls_d_rdata0, ls_d_rdata1, ls_d_wdata0, ls_d_wdata1;
   logic        ls_d_we, ls_d_wpair, ls_err;
   logic [2:0]  au_d_ridx0, au_d_ridx1, au_d_widx;
   logic [31:0] au_d_rdata0, au_d_rdata1, au_d_wdata0, au_d_wdata1;
   logic        au_d_we, au_d_wpair;
   logic [2:0]  au_c_ridx0, au_c_ridx1, au_c_widx;
   logic [39:0] au_c_rdata0, au_c_rdata1, au_c_wdata0, au_c_wdata1;
   logic        au_c_we, au_c_wpair, au_err;

   always #2.5 clk = ~clk;

   pp_regfile u_pp_regfile (.*);

   logic [31:0] m_a [8];
   logic [31:0] m_p [8];
   logic [31:0] m_q [8];
   logic [39:0] m_c [8];
   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   function automatic logic [31:0] dval(bit on_q, int i);
      return on_q ? m_q[i] : m_p[i];
   endfunction

   task automatic chk(string tag, logic [39:0] got, logic [39:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic quiet();
      ls_a_we0 = 0; ls_a_we1 = 0; ls_d_we = 0; au_d_we = 0; au_c_we = 0;
      ls_d_wpair = 0; au_d_wpair = 0; au_c_wpair = 0;
      ls_a_widx0 = 0; ls_a_widx1 = 0; ls_d_widx = 0; au_d_widx = 0; au_c_widx = 0;
      ls_a_wdata0 = 0; ls_a_wdata1 = 0; ls_d_wdata0 = 0; ls_d_wdata1 = 0;
      au_d_wdata0 = 0; au_d_wdata1 = 0; au_c_wdata0 = 0; au_c_wdata1 = 0;
   endtask

   // reads every space under both swap values, no writes (R4, R9, R5 hold)
   task automatic readback(string tag);
      for (int pp = 0; pp < 2; pp++) begin
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            quiet();
            pp_idx = pp[0];
            ls_a_ridx0 = 3'(i); ls_a_ridx1 = 3'(7 - i);
            ls_d_ridx0 = 3'(i); ls_d_ridx1 = 3'(7 - i);
            au_d_ridx0 = 3'(i); au_d_ridx1 = 3'(7 - i);
            au_c_ridx0 = 3'(i); au_c_ridx1 = 3'(7 - i);
            #1;
            chk({tag, " R4 ls data port0"}, 40'(ls_d_rdata0), 40'(dval(pp[0], i)));
            chk({tag, " R9 ls data port1"}, 40'(ls_d_rdata1), 40'(dval(pp[0], 7 - i)));
            chk({tag, " R4 au data port0"}, 40'(au_d_rdata0), 40'(dval(!pp[0], i)));
            chk({tag, " R9 au data port1"}, 40'(au_d_rdata1), 40'(dval(!pp[0], 7 - i)));
            if (pp == 0) begin
               chk({tag, " R2 addr port0"}, 40'(ls_a_rdata0), 40'(m_a[i]));
               chk({tag, " R9 addr port1"}, 40'(ls_a_rdata1), 40'(m_a[7 - i]));
               chk({tag, " R3 acc port0"}, au_c_rdata0, m_c[i]);
               chk({tag, " R9 acc port1"}, au_c_rdata1, m_c[7 - i]);
               chk({tag, " R7 idle ls_err"}, 40'(ls_err), 40'(0));
               chk({tag, " R7 idle au_err"}, 40'(au_err), 40'(0));
            end
         end
      end
   endtask

   // one cycle driving all five write paths at once (R8)
   task automatic op(int pp, int idx, int pair, int step);
      logic [2:0]  li, di, ci, a1;
      logic [31:0] ld0, ld1, ad0, ad1, xa0, xa1;
      logic [39:0] cd0, cd1;
      bit          lbad, dbad, cbad;
      li  = 3'(idx);
      di  = li ^ 3'b110;
      ci  = li ^ {2'b00, li[1]};
      a1  = (pair != 0) ? li : 3'((idx + 3) % 8);
      ld0 = 32'hA000_0000 | 32'(step << 8) | 32'(idx);
      ld1 = ~ld0;
      ad0 = 32'h5000_0000 + 32'(step * 3);
      ad1 = ad0 ^ 32'h0F0F_0F0F;
      cd0 = {8'(step), 32'hC0DE_0000 + 32'(idx)};
      cd1 = {8'h3C, 32'(step * 7)};
      xa0 = 32'h0000_1000 + 32'(step);
      xa1 = 32'h0000_2000 + 32'(step);
      lbad = (pair != 0) && li[0];
      dbad = (pair != 0) && di[0];
      cbad = (pair != 0) && ci[0];

      @(negedge clk);
      pp_idx = pp[0];
      ls_d_we = 1; ls_d_wpair = pair[0]; ls_d_widx = li; ls_d_wdata0 = ld0; ls_d_wdata1 = ld1;
      au_d_we = 1; au_d_wpair = pair[0]; au_d_widx = di; au_d_wdata0 = ad0; au_d_wdata1 = ad1;
      au_c_we = 1; au_c_wpair = pair[0]; au_c_widx = ci; au_c_wdata0 = cd0; au_c_wdata1 = cd1;
      ls_a_we0 = 1; ls_a_widx0 = li; ls_a_wdata0 = xa0;
      ls_a_we1 = 1; ls_a_widx1 = a1; ls_a_wdata1 = xa1;
      ls_d_ridx0 = li; au_d_ridx0 = di; au_c_ridx0 = ci; ls_a_ridx0 = li;
      #1;
      chk("R5 ls data old value", 40'(ls_d_rdata0), 40'(dval(pp[0], int'(li))));
      chk("R5 au data old value", 40'(au_d_rdata0), 40'(dval(!pp[0], int'(di))));
      chk("R5 acc old value", au_c_rdata0, m_c[ci]);
      chk("R5 addr old value", 40'(ls_a_rdata0), 40'(m_a[li]));
      chk("R7 ls_err", 40'(ls_err), 40'(lbad));
      chk("R7 au_err", 40'(au_err), 40'(dbad | cbad));
      @(posedge clk);
      // expected state from the requirements
      if (!lbad) begin
         if (pp != 0) m_q[li] = ld0; else m_p[li] = ld0;
         if (pair != 0) begin
            if (pp != 0) m_q[li + 1] = ld1; else m_p[li + 1] = ld1;
         end
      end
      if (!dbad) begin
         if (pp != 0) m_p[di] = ad0; else m_q[di] = ad0;
         if (pair != 0) begin
            if (pp != 0) m_p[di + 1] = ad1; else m_q[di + 1] = ad1;
         end
      end
      if (!cbad) begin
         m_c[ci] = cd0;
         if (pair != 0) m_c[ci + 1] = cd1;
      end
      m_a[li] = xa0;
      m_a[a1] = xa1;   // port 1 overrides on equal index (R2)
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_a[i] = '0; m_p[i] = '0; m_q[i] = '0; m_c[i] = '0;
      end
      quiet();
      pp_idx = 0;
      ls_a_ridx0 = 0; ls_a_ridx1 = 0; ls_d_ridx0 = 0; ls_d_ridx1 = 0;
      au_d_ridx0 = 0; au_d_ridx1 = 0; au_c_ridx0 = 0; au_c_ridx1 = 0;
      ls_d_we = 1; ls_d_wdata0 = 32'hFFFF_FFFF;  // must be ignored in reset (R1)
      repeat (3) @(posedge clk);
      @(negedge clk);
      quiet();
      rst_n = 1;
      readback("R1 reset");
      for (int pp = 0; pp < 2; pp++) begin
         for (int idx = 0; idx < 8; idx++) begin
            for (int pair = 0; pair < 2; pair++) begin
               op(pp, idx, pair, pp * 16 + idx * 2 + pair);
               readback("R6 sweep");
            end
         end
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule